// File: doc/BRIEF.md
# Banked Effective Address Generator

This block works out the 24-bit effective address of one instruction operand for a processor with 16-bit index, direct-page and stack registers and an 8-bit bank for program and data. A request carries an addressing-mode code, an access class, up to three operand bytes taken from the instruction stream, the value the program counter has just past the opcode, and a snapshot of the registers. Modes that compute the address from the operand and registers alone finish on the cycle after the request is taken. Indirect modes first read a 16-bit or 24-bit pointer one byte at a time over a read port, and then finish.

Each result returns the address, how many operand bytes the program counter skips, a cost in cycles, and an open-bus byte. The open-bus byte is a latch that holds the last value seen on the data bus.

Requests use valid/ready. `req_ready` is high only when the block is idle, and a request is taken on a clock edge where both `req_valid` and `req_ready` are high. The pointer read port also uses valid/ready. The block raises `mem_rd_valid` with an address and holds both until the memory returns `mem_rd_ready`. The byte on `mem_rd_data` is taken in that same cycle. The memory can stall for any number of cycles.

Top module: `ea_gen`

## Requirements
- R1: After reset `req_ready` is 1 and `done`, `mem_rd_valid` and `open_bus` are 0. A request is taken only while `req_ready` is 1. While a request is being worked on, `req_ready` is 0 and changes on the request inputs have no effect. `done` is high for exactly one cycle. For a mode that is not indirect, `done` is high in the cycle right after the request is taken.
- R2: The direct-page codes work on the first operand byte b0 and give an address in bank 0. Code 9 gives (D+b0) mod 2^16. Codes 10 and 11 add X or Y to D+b0 and keep the low 8 bits when `emu`=1, or the low 16 bits when `emu`=0. Code 17 (stack-relative) gives (S+b0) mod 2^16.
- R3: The absolute codes use the little-endian 16-bit operand W={b1,b0}. Code 4 gives DB·2^16+W, code 5 adds X and code 6 adds Y, all mod 2^24. Code 7 gives the 24-bit operand {b2,b1,b0}, and code 8 adds X to it, mod 2^24.
- R4: Immediate codes 0 and 1 give PB·2^16+PC. Relative codes give a bank-0 address mod 2^16. Code 2 adds PC+1 to b0 sign-extended, and code 3 adds PC+2 to W.
- R5: An indirect mode reads the pointer bytes at P, P+1 and, for a long pointer, P+2, in that order and little-endian. The address and `mem_rd_valid` stay steady until `mem_rd_ready` is high.
- R6: For the direct-page indirect codes the pointer is P=(D+b0) mod 2^16, except code 16, where P=(D+b0+X) mod 2^16. Code 12 gives DB·2^16+ptr16. Code 14 gives that plus Y, mod 2^24. Code 16 gives DB·2^16+ptr16. Codes 13 and 15 read a long pointer: code 13 gives ptr24 and code 15 gives ptr24+Y, mod 2^24.
- R7: Code 18 reads a 16-bit pointer at (S+b0) mod 2^16 and gives (ptr16+DB·2^16+Y) mod 2^24.
- R8: Code 19 reads ptr16 at W in bank 0 and gives PB·2^16+ptr16. Code 20 reads ptr24 at W and gives ptr24. Code 21 reads ptr16 at PB·2^16+((W+X) mod 2^16) and gives ptr16 in bank 0.
- R9: `pc_inc` is 1 for codes 0, 2, 9–18 and 2 for codes 1, 3–6, 19–21. It is 3 for codes 7 and 8.
- R10: `cycles` is `pc_inc` plus an internal count. The internal count is 1 for codes 10, 11 and 17, 2 for code 18 and 0 for all other codes.
- R11: The access class is 0 none, 1 read, 2 write, 3 modify or 4 jump. Classes 1 and 3 count as a read. An indirect mode always loads `open_bus` with its pointer-address operand byte: b1 for codes 19–21 and b0 for the others. On a read it then loads the last pointer byte. A mode that is not indirect loads the top operand byte on a read: b0 for direct and stack codes, b1 for codes 4–6, b2 for codes 7–8.
- R12: `open_bus` keeps its value for immediate and relative codes, and for a mode that is not indirect under classes 0, 2 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_mode | input | 5 | Addressing-mode code |
| req_acc | input | 3 | Access class |
| req_op | input | 24 | Operand bytes, first byte in [7:0] |
| req_pc | input | 16 | Program counter just past the opcode |
| reg_x | input | 16 | Index X |
| reg_y | input | 16 | Index Y |
| reg_d | input | 16 | Direct-page base |
| reg_s | input | 16 | Stack pointer |
| reg_pbank | input | 8 | Program bank |
| reg_dbank | input | 8 | Data bank |
| emu | input | 1 | Emulation-mode flag |
| mem_rd_valid | output | 1 | Pointer byte read request |
| mem_rd_addr | output | 24 | Pointer byte address |
| mem_rd_ready | input | 1 | Read accepted, data valid |
| mem_rd_data | input | 8 | Read data |
| done | output | 1 | Result valid pulse |
| ea | output | 24 | Effective address |
| pc_inc | output | 2 | Program-counter advance |
| cycles | output | 3 | Cycle cost |
| open_bus | output | 8 | Open-bus latch |

## Verification
The bench runs every mode code with both `emu` values and all five access classes, over six register and operand sets. Two of the sets are built to make each wrap show up. One has an all-ones index with a near-top D to separate the 8-bit, 16-bit and 24-bit masks. One has offsets with bit 7 set and a program counter near 0xFFFF to show whether relative branches sign-extend and wrap. Other sets have a D base above 0xFF, which makes the 8-bit emulation mask differ from the 16-bit one. The memory returns a byte that depends on the address, stalls every third cycle, and has unequal low and high bytes, so a wrong read order, a wrong pointer address or a broken hold under back-pressure changes the result. Running the same mode under different access classes shows whether the open-bus update follows the class.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 16;
  localparam int BANK_W = 8;
  localparam int ADDR_W = REG_W + BANK_W;
  localparam int OPB_N  = 3;
  localparam int MODE_W = 5;
  localparam int ACC_W  = 3;

  typedef enum logic [MODE_W-1:0] {
    M_IMM8      = 5'd0,
    M_IMM16     = 5'd1,
    M_REL8      = 5'd2,
    M_REL16     = 5'd3,
    M_ABS       = 5'd4,
    M_ABS_X     = 5'd5,
    M_ABS_Y     = 5'd6,
    M_LONG      = 5'd7,
    M_LONG_X    = 5'd8,
    M_DP        = 5'd9,
    M_DP_X      = 5'd10,
    M_DP_Y      = 5'd11,
    M_DP_IND    = 5'd12,
    M_DP_IND_L  = 5'd13,
    M_DP_IND_Y  = 5'd14,
    M_DP_IND_LY = 5'd15,
    M_DP_X_IND  = 5'd16,
    M_SR        = 5'd17,
    M_SR_IND_Y  = 5'd18,
    M_ABS_IND   = 5'd19,
    M_ABS_IND_L = 5'd20,
    M_ABS_X_IND = 5'd21
  } ea_mode_e;

  typedef enum logic [ACC_W-1:0] {
    ACC_NONE   = 3'd0,
    ACC_READ   = 3'd1,
    ACC_WRITE  = 3'd2,
    ACC_MODIFY = 3'd3,
    ACC_JUMP   = 3'd4
  } ea_acc_e;

  typedef struct packed {
    logic       indirect;
    logic       ptr_long;
    logic [1:0] pc_inc;
    logic [1:0] extra;
    logic       ob_on_read;
  } ea_info_t;
endpackage

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
  import ea_pkg::*;
(
  input  logic [MODE_W-1:0]         mode,
  input  logic [OPB_N*BYTE_W-1:0]   op,
  input  logic [REG_W-1:0]          reg_x,
  input  logic [REG_W-1:0]          reg_d,
  input  logic [REG_W-1:0]          reg_s,
  input  logic [BANK_W-1:0]         pbank,
  output ea_info_t                  info,
  output logic [ADDR_W-1:0]         ptr_addr,
  output logic [BYTE_W-1:0]         ob_byte
);
  logic [BYTE_W-1:0] b0, b1, b2;
  logic [REG_W-1:0]  w16, dp_sum, dpx_sum, sr_sum, absx_sum;

  assign b0       = op[BYTE_W-1:0];
  assign b1       = op[2*BYTE_W-1:BYTE_W];
  assign b2       = op[3*BYTE_W-1:2*BYTE_W];
  assign w16      = {b1, b0};
  assign dp_sum   = reg_d + {{(REG_W-BYTE_W){1'b0}}, b0};
  assign dpx_sum  = dp_sum + reg_x;
  assign sr_sum   = reg_s + {{(REG_W-BYTE_W){1'b0}}, b0};
  assign absx_sum = w16 + reg_x;

  always_comb begin
    info     = '0;
    ptr_addr = '0;
    ob_byte  = b0;
    case (ea_mode_e'(mode))
      M_IMM16, M_REL16: info.pc_inc = 2'd2;
      M_ABS, M_ABS_X, M_ABS_Y: begin
        info.pc_inc     = 2'd2;
        info.ob_on_read = 1'b1;
        ob_byte         = b1;
      end
      M_LONG, M_LONG_X: begin
        info.pc_inc     = 2'd3;
        info.ob_on_read = 1'b1;
        ob_byte         = b2;
      end
      M_DP: begin
        info.pc_inc     = 2'd1;
        info.ob_on_read = 1'b1;
      end
      M_DP_X, M_DP_Y, M_SR: begin
        info.pc_inc     = 2'd1;
        info.extra      = 2'd1;
        info.ob_on_read = 1'b1;
      end
      M_DP_IND, M_DP_IND_Y: begin
        info.pc_inc   = 2'd1;
        info.indirect = 1'b1;
        ptr_addr      = {{BANK_W{1'b0}}, dp_sum};
      end
      M_DP_IND_L, M_DP_IND_LY: begin
        info.pc_inc   = 2'd1;
        info.indirect = 1'b1;
        info.ptr_long = 1'b1;
        ptr_addr      = {{BANK_W{1'b0}}, dp_sum};
      end
      M_DP_X_IND: begin
        info.pc_inc   = 2'd1;
        info.indirect = 1'b1;
        ptr_addr      = {{BANK_W{1'b0}}, dpx_sum};
      end
      M_SR_IND_Y: begin
        info.pc_inc   = 2'd1;
        info.extra    = 2'd2;
        info.indirect = 1'b1;
        ptr_addr      = {{BANK_W{1'b0}}, sr_sum};
      end
      M_ABS_IND: begin
        info.pc_inc   = 2'd2;
        info.indirect = 1'b1;
        ptr_addr      = {{BANK_W{1'b0}}, w16};
        ob_byte       = b1;
      end
      M_ABS_IND_L: begin
        info.pc_inc   = 2'd2;
        info.indirect = 1'b1;
        info.ptr_long = 1'b1;
        ptr_addr      = {{BANK_W{1'b0}}, w16};
        ob_byte       = b1;
      end
      M_ABS_X_IND: begin
        info.pc_inc   = 2'd2;
        info.indirect = 1'b1;
        ptr_addr      = {pbank, absx_sum};
        ob_byte       = b1;
      end
      default: info.pc_inc = 2'd1;
    endcase
  end
endmodule

// File: rtl/ea_ptr_fetch.sv
module ea_ptr_fetch
  import ea_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = BYTE_W,
  parameter int NB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic          long_ptr,
  output logic          rd_valid,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ready,
  input  logic [DW-1:0] rd_data,
  output logic [NB*DW-1:0] ptr_val,
  output logic          beat_last
);
  localparam int CW = $clog2(NB);

  logic          busy_q, long_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] base_q;
  logic          hs, is_last;

  assign rd_valid  = busy_q;
  assign rd_addr   = base_q + {{(AW-CW){1'b0}}, cnt_q};
  assign hs        = busy_q & rd_ready;
  assign is_last   = long_q ? (cnt_q == CW'(NB-1)) : (cnt_q == CW'(NB-2));
  assign beat_last = hs & is_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      long_q <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      long_q <= long_ptr;
      cnt_q  <= '0;
      base_q <= base;
    end else if (hs) begin
      cnt_q <= cnt_q + 1'b1;
      if (is_last) busy_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic [DW-1:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          byte_q <= '0;
      else if (start)                      byte_q <= '0;
      else if (hs && cnt_q == CW'(g))      byte_q <= rd_data;
    end
    assign ptr_val[g*DW +: DW] = byte_q;
  end
endmodule

// File: rtl/ea_addr_form.sv
module ea_addr_form
  import ea_pkg::*;
(
  input  logic [MODE_W-1:0]       mode,
  input  logic [OPB_N*BYTE_W-1:0] op,
  input  logic [REG_W-1:0]        reg_x,
  input  logic [REG_W-1:0]        reg_y,
  input  logic [REG_W-1:0]        reg_d,
  input  logic [REG_W-1:0]        reg_s,
  input  logic [BANK_W-1:0]       pbank,
  input  logic [BANK_W-1:0]       dbank,
  input  logic                    emu,
  input  logic [REG_W-1:0]        pc,
  input  logic [ADDR_W-1:0]       ptr,
  output logic [ADDR_W-1:0]       ea
);
  localparam logic [BANK_W-1:0] BANK0 = '0;

  logic [BYTE_W-1:0] b0;
  logic [REG_W-1:0]  w16, dp_sum, sr_sum, dpi_sum, rel8, rel16, ptr16;
  logic [ADDR_W-1:0] x24, y24, dbase, op24;

  assign b0      = op[BYTE_W-1:0];
  assign w16     = op[REG_W-1:0];
  assign op24    = op[ADDR_W-1:0];
  assign ptr16   = ptr[REG_W-1:0];
  assign x24     = {BANK0, reg_x};
  assign y24     = {BANK0, reg_y};
  assign dbase   = {dbank, {REG_W{1'b0}}};
  assign dp_sum  = reg_d + {{(REG_W-BYTE_W){1'b0}}, b0};
  assign sr_sum  = reg_s + {{(REG_W-BYTE_W){1'b0}}, b0};
  assign rel8    = pc + REG_W'(1) + {{(REG_W-BYTE_W){b0[BYTE_W-1]}}, b0};
  assign rel16   = pc + REG_W'(2) + w16;

  always_comb begin
    dpi_sum = dp_sum + ((ea_mode_e'(mode) == M_DP_Y) ? reg_y : reg_x);
    if (emu) dpi_sum = {{(REG_W-BYTE_W){1'b0}}, dpi_sum[BYTE_W-1:0]};
  end

  always_comb begin
    case (ea_mode_e'(mode))
      M_IMM8, M_IMM16: ea = {pbank, pc};
      M_REL8:          ea = {BANK0, rel8};
      M_REL16:         ea = {BANK0, rel16};
      M_ABS:           ea = dbase + {BANK0, w16};
      M_ABS_X:         ea = dbase + {BANK0, w16} + x24;
      M_ABS_Y:         ea = dbase + {BANK0, w16} + y24;
      M_LONG:          ea = op24;
      M_LONG_X:        ea = op24 + x24;
      M_DP:            ea = {BANK0, dp_sum};
      M_DP_X, M_DP_Y:  ea = {BANK0, dpi_sum};
      M_SR:            ea = {BANK0, sr_sum};
      M_DP_IND,
      M_DP_X_IND:      ea = {dbank, ptr16};
      M_DP_IND_Y,
      M_SR_IND_Y:      ea = {dbank, ptr16} + y24;
      M_DP_IND_L,
      M_ABS_IND_L:     ea = ptr;
      M_DP_IND_LY:     ea = ptr + y24;
      M_ABS_IND:       ea = {pbank, ptr16};
      M_ABS_X_IND:     ea = {BANK0, ptr16};
      default:         ea = {pbank, pc};
    endcase
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [MODE_W-1:0]       req_mode,
  input  logic [ACC_W-1:0]        req_acc,
  input  logic [OPB_N*BYTE_W-1:0] req_op,
  input  logic [REG_W-1:0]        req_pc,
  input  logic [REG_W-1:0]        reg_x,
  input  logic [REG_W-1:0]        reg_y,
  input  logic [REG_W-1:0]        reg_d,
  input  logic [REG_W-1:0]        reg_s,
  input  logic [BANK_W-1:0]       reg_pbank,
  input  logic [BANK_W-1:0]       reg_dbank,
  input  logic                    emu,
  output logic                    mem_rd_valid,
  output logic [ADDR_W-1:0]       mem_rd_addr,
  input  logic                    mem_rd_ready,
  input  logic [BYTE_W-1:0]       mem_rd_data,
  output logic                    done,
  output logic [ADDR_W-1:0]       ea,
  output logic [1:0]              pc_inc,
  output logic [2:0]              cycles,
  output logic [BYTE_W-1:0]       open_bus
);
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_DONE} st_e;

  st_e                     st_q;
  logic                    accept, is_read, acc_read_q, beat_last;
  ea_info_t                info, info_q;
  logic [ADDR_W-1:0]       ptr_addr;
  logic [BYTE_W-1:0]       ob_byte;
  logic [OPB_N*BYTE_W-1:0] ptr_val;
  logic [MODE_W-1:0]       mode_q;
  logic [OPB_N*BYTE_W-1:0] op_q;
  logic [REG_W-1:0]        pc_q, x_q, y_q, d_q, s_q;
  logic [BANK_W-1:0]       pb_q, db_q;
  logic                    emu_q;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid & req_ready;
  assign is_read   = (ea_acc_e'(req_acc) == ACC_READ) || (ea_acc_e'(req_acc) == ACC_MODIFY);
  assign done      = (st_q == ST_DONE);
  assign pc_inc    = info_q.pc_inc;
  assign cycles    = {1'b0, info_q.pc_inc} + {1'b0, info_q.extra};

  ea_mode_decode u_dec (
    .mode(req_mode), .op(req_op), .reg_x(reg_x), .reg_d(reg_d),
    .reg_s(reg_s), .pbank(reg_pbank), .info(info), .ptr_addr(ptr_addr),
    .ob_byte(ob_byte)
  );

  ea_ptr_fetch #(.AW(ADDR_W), .DW(BYTE_W), .NB(OPB_N)) u_fetch (
    .clk(clk), .rst_n(rst_n), .start(accept & info.indirect),
    .base(ptr_addr), .long_ptr(info.ptr_long),
    .rd_valid(mem_rd_valid), .rd_addr(mem_rd_addr), .rd_ready(mem_rd_ready),
    .rd_data(mem_rd_data), .ptr_val(ptr_val), .beat_last(beat_last)
  );

  ea_addr_form u_form (
    .mode(mode_q), .op(op_q), .reg_x(x_q), .reg_y(y_q), .reg_d(d_q),
    .reg_s(s_q), .pbank(pb_q), .dbank(db_q), .emu(emu_q), .pc(pc_q),
    .ptr(ptr_val), .ea(ea)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE:  if (accept) st_q <= info.indirect ? ST_FETCH : ST_DONE;
        ST_FETCH: if (beat_last) st_q <= ST_DONE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      info_q     <= '0;
      acc_read_q <= 1'b0;
      mode_q     <= '0;
      op_q       <= '0;
      pc_q       <= '0;
      x_q        <= '0;
      y_q        <= '0;
      d_q        <= '0;
      s_q        <= '0;
      pb_q       <= '0;
      db_q       <= '0;
      emu_q      <= 1'b0;
    end else if (accept) begin
      info_q     <= info;
      acc_read_q <= is_read;
      mode_q     <= req_mode;
      op_q       <= req_op;
      pc_q       <= req_pc;
      x_q        <= reg_x;
      y_q        <= reg_y;
      d_q        <= reg_d;
      s_q        <= reg_s;
      pb_q       <= reg_pbank;
      db_q       <= reg_dbank;
      emu_q      <= emu;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_bus <= '0;
    end else if (accept && (info.indirect || (info.ob_on_read && is_read))) begin
      open_bus <= ob_byte;
    end else if (beat_last && acc_read_q) begin
      open_bus <= mem_rd_data;
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        mem_rd_valid,
  input logic [23:0] mem_rd_addr,
  input logic        mem_rd_ready,
  input logic        done,
  input logic [1:0]  pc_inc,
  input logic [2:0]  cycles,
  input logic [7:0]  open_bus
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R1
  AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid || done) |-> !req_ready); // R1
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R5
  AST_PC_INC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pc_inc != 2'd0)); // R9
  AST_CYCLE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((cycles >= {1'b0, pc_inc}) && (cycles <= {1'b0, pc_inc} + 3'd2))); // R10
  AST_OB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!(req_valid && req_ready) && !(mem_rd_valid && mem_rd_ready)) |=> $stable(open_bus)); // R11
endmodule

bind ea_gen ea_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
  .mem_rd_ready(mem_rd_ready), .done(done), .pc_inc(pc_inc),
  .cycles(cycles), .open_bus(open_bus)
);

// File: tb/ea_gen_test.sv
module ea_gen_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, req_valid, req_ready, emu;
  logic [4:0]  req_mode;
  logic [2:0]  req_acc;
  logic [23:0] req_op;
  logic [15:0] req_pc, reg_x, reg_y, reg_d, reg_s;
  logic [7:0]  reg_pbank, reg_dbank;
  logic        mem_rd_valid, mem_rd_ready, done;
  logic [23:0] mem_rd_addr, ea;
  logic [7:0]  mem_rd_data, open_bus;
  logic [1:0]  pc_inc, stall_cnt;
  logic [2:0]  cycles;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  ea_gen uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_acc(req_acc), .req_op(req_op), .req_pc(req_pc),
    .reg_x(reg_x), .reg_y(reg_y), .reg_d(reg_d), .reg_s(reg_s),
    .reg_pbank(reg_pbank), .reg_dbank(reg_dbank), .emu(emu),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data), .done(done),
    .ea(ea), .pc_inc(pc_inc), .cycles(cycles), .open_bus(open_bus)
  );

  function automatic logic [7:0] memf(logic [23:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ (a[23:16] + 8'h5C);
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stall_cnt <= 2'd0;
    else        stall_cnt <= (stall_cnt == 2'd2) ? 2'd0 : stall_cnt + 2'd1;
  assign mem_rd_ready = (stall_cnt != 2'd1);
  assign mem_rd_data  = memf(mem_rd_addr);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [7:0] ob_model = 8'h00;

  task automatic run(int m, int acc, int e);
    logic [7:0]  b0, b1, b2, w_lo, w_hi, w_bk;
    logic [15:0] w, dp, sr, t16;
    logic [23:0] p, exp_ea;
    int inc, extra, lat;
    bit ind, lng, rd;
    string tg;
    b0 = req_op[7:0]; b1 = req_op[15:8]; b2 = req_op[23:16];
    w  = {b1, b0};
    dp = reg_d + {8'h00, b0};
    sr = reg_s + {8'h00, b0};
    rd = (acc == 1) || (acc == 3);
    ind = (m >= 12 && m <= 16) || m >= 18;
    lng = (m == 13) || (m == 15) || (m == 20);
    p = 24'h0;
    if (m == 16)      p = {8'h00, dp + reg_x};
    else if (m == 18) p = {8'h00, sr};
    else if (m == 19 || m == 20) p = {8'h00, w};
    else if (m == 21) p = {reg_pbank, w + reg_x};
    else              p = {8'h00, dp};
    w_lo = memf(p); w_hi = memf(p + 24'd1); w_bk = memf(p + 24'd2);
    tg = "R4";
    case (m)
      0, 1:   exp_ea = {reg_pbank, req_pc};
      2: begin t16 = req_pc + 16'd1 + {{8{b0[7]}}, b0}; exp_ea = {8'h00, t16}; end
      3: begin t16 = req_pc + 16'd2 + w; exp_ea = {8'h00, t16}; end
      4: begin exp_ea = {reg_dbank, 16'h0} + {8'h0, w}; tg = "R3"; end
      5: begin exp_ea = {reg_dbank, 16'h0} + {8'h0, w} + {8'h0, reg_x}; tg = "R3"; end
      6: begin exp_ea = {reg_dbank, 16'h0} + {8'h0, w} + {8'h0, reg_y}; tg = "R3"; end
      7: begin exp_ea = req_op; tg = "R3"; end
      8: begin exp_ea = req_op + {8'h0, reg_x}; tg = "R3"; end
      9: begin exp_ea = {8'h0, dp}; tg = "R2"; end
      10, 11: begin
        t16 = dp + ((m == 10) ? reg_x : reg_y);
        if (e == 1) t16 = {8'h00, t16[7:0]};
        exp_ea = {8'h0, t16}; tg = "R2";
      end
      12, 16: begin exp_ea = {reg_dbank, w_hi, w_lo}; tg = "R6"; end
      13: begin exp_ea = {w_bk, w_hi, w_lo}; tg = "R6"; end
      14: begin exp_ea = {reg_dbank, w_hi, w_lo} + {8'h0, reg_y}; tg = "R6"; end
      15: begin exp_ea = {w_bk, w_hi, w_lo} + {8'h0, reg_y}; tg = "R6"; end
      17: begin exp_ea = {8'h0, sr}; tg = "R2"; end
      18: begin exp_ea = {8'h0, w_hi, w_lo} + {reg_dbank, 16'h0} + {8'h0, reg_y}; tg = "R7"; end
      19: begin exp_ea = {reg_pbank, w_hi, w_lo}; tg = "R8"; end
      20: begin exp_ea = {w_bk, w_hi, w_lo}; tg = "R8"; end
      default: begin exp_ea = {8'h00, w_hi, w_lo}; tg = "R8"; end
    endcase
    if (m == 7 || m == 8) inc = 3;
    else if (m == 1 || (m >= 3 && m <= 6) || m >= 19) inc = 2;
    else inc = 1;
    extra = (m == 10 || m == 11 || m == 17) ? 1 : (m == 18) ? 2 : 0;
    if (ind) begin
      ob_model = (m >= 19) ? b1 : b0;
      if (rd) ob_model = lng ? w_bk : w_hi;
    end else if (rd && m >= 4) begin
      ob_model = (m == 7 || m == 8) ? b2 : (m >= 4 && m <= 6) ? b1 : b0;
    end

    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    // R1: inputs scrambled while busy must have no effect
    req_mode = 5'(m + 7); req_op = ~req_op; reg_x = ~reg_x; reg_y = reg_y ^ 16'h5A5A;
    reg_d = reg_d + 16'h0101; reg_s = ~reg_s; reg_pbank = ~reg_pbank; reg_dbank = ~reg_dbank;
    req_pc = ~req_pc; emu = ~emu; req_acc = 3'(acc ^ 1);
    lat = 1;
    while (!done && lat < 40) begin
      if (req_ready !== 1'b0) chk("R1 ready while busy", {31'd0, req_ready}, 32'd0);
      @(negedge clk);
      lat++;
    end
    req_valid = 1'b0;
    chk("R1 done seen", {31'd0, done}, 32'd1);
    if (!ind) chk("R1 latency", lat, 1);
    else      chk("R5 latency", {31'd0, (lat >= (lng ? 4 : 3))}, 32'd1);
    chk($sformatf("%s ea mode %0d emu %0d", tg, m, e), {8'h0, ea}, {8'h0, exp_ea});
    chk($sformatf("R9 pc_inc mode %0d", m), {30'd0, pc_inc}, inc);
    chk($sformatf("R10 cycles mode %0d", m), {29'd0, cycles}, inc + extra);
    chk($sformatf("%s open_bus mode %0d acc %0d", (ind || (rd && m >= 4)) ? "R11" : "R12", m, acc),
        {24'd0, open_bus}, {24'd0, ob_model});
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_mode = '0; req_acc = '0; req_op = '0;
    req_pc = '0; reg_x = '0; reg_y = '0; reg_d = '0; reg_s = '0;
    reg_pbank = '0; reg_dbank = '0; emu = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R1 reset done", {31'd0, done}, 32'd0);
    chk("R1 reset rd_valid", {31'd0, mem_rd_valid}, 32'd0);
    chk("R1 reset open_bus", {24'd0, open_bus}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int pat = 0; pat < 6; pat++) begin
      for (int e = 0; e < 2; e++) begin
        for (int acc = 0; acc < 5; acc++) begin
          for (int m = 0; m < 22; m++) begin
            case (pat)
              0: begin reg_x = 16'h0003; reg_y = 16'h0010; reg_d = 16'h0000; reg_s = 16'h01F0;
                       reg_pbank = 8'h01; reg_dbank = 8'h02; req_pc = 16'h8000; req_op = 24'h563412; end
              1: begin reg_x = 16'hFFFF; reg_y = 16'hFFFF; reg_d = 16'hFF80; reg_s = 16'hFFF0;
                       reg_pbank = 8'hFE; reg_dbank = 8'hFF; req_pc = 16'hFFFE; req_op = 24'hFFFF90; end
              2: begin reg_x = 16'h00F0; reg_y = 16'h8000; reg_d = 16'h0120; reg_s = 16'h1234;
                       reg_pbank = 8'h7F; reg_dbank = 8'h80; req_pc = 16'h0000; req_op = 24'h80007F; end
              default: begin
                reg_x = 16'(pat * 16'h1357); reg_y = 16'(pat * 16'h2468);
                reg_d = 16'(pat * 16'h0F31); reg_s = 16'(pat * 16'h3C07);
                reg_pbank = 8'(pat * 8'h29); reg_dbank = 8'(pat * 8'h53);
                req_pc = 16'(pat * 16'h4D11); req_op = 24'(pat * 24'h9A3B71);
              end
            endcase
            emu = e[0];
            req_mode = 5'(m);
            req_acc = 3'(acc);
            run(m, acc, e);
          end
        end
      end
    end
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule